// File: doc/BRIEF.md
# Mixed Sample Packetizer

This block sits between an 8-bit sampling converter, a 1-bit digital read line and a 9-bit-wide synchronous FIFO. On every sample tick it stores one converter byte and one digital bit. The digital bit first passes through a two-flop synchroniser. After eight ticks the block has a complete set of samples and turns it into a 10-word packet. It writes that packet to the FIFO one word per clock and marks the first word of each packet with the ninth FIFO bit.

Collection and output are double-buffered, so the next eight samples are gathered while the previous packet drains. The writer pauses whenever the FIFO reports full. If a packet is complete while the writer is still busy with the earlier one, the new packet is dropped whole. The next header that reaches the FIFO then carries an overflow flag. Every packet carries a 4-bit rolling sequence number, so the host can see which packets are missing.

The writer is a four-state machine:
- `W_IDLE`: no packet is held.
- `W_HEAD`: the header word is presented.
- `W_DATA`: the eight converter bytes go out.
- `W_DIGI`: the packed digital byte is presented.

Its transitions are:
- IDLE→HEAD when a packet is ready.
- HEAD→DATA on the header write.
- DATA→DATA on each write of a converter byte except the last one.
- DATA→DIGI on the write of the last converter byte.
- DIGI→HEAD on the final write, when a new packet is ready in that same cycle.
- DIGI→IDLE on the final write, when no new packet is ready.

Top module: `sample_packetizer`

## Requirements
- R1: After reset `fifo_wr` stays low until the first packet is complete. The first header carries sequence 0 with the overflow flag clear.
- R2: The digital bit stored for a tick is the level `dig_in` had at the clock edge two edges before the capturing edge. A change of `dig_in` one clock before that edge is not seen.
- R3: A packet is exactly 10 FIFO words in this order:
  - word 0: the header;
  - words 1 to 8: the eight converter samples, oldest first;
  - word 9: the digital byte, in which bit 0 holds the oldest digital sample and bit 7 the newest.
- R4: FIFO bit 8 is 1 on the header word and 0 on the other nine words.
- R5: Header bits 3:0 hold the sequence number, bit 4 holds the overflow flag, and bits 7:5 are 0.
- R6: The sequence number rises by one for every completed packet, including dropped ones, and wraps from 15 to 0.
- R7: `fifo_wr` is never high while `fifo_full` is high. While the writer is stalled, `fifo_din` holds its value.
- R8: Packets are not lost while each packet finishes writing before the next one completes, even when the FIFO is full on some cycles.
- R9: A packet that completes while the writer is busy is discarded whole. The next header written has the overflow flag set, and the flag is cleared again after that header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | Sample strobe, one clock wide |
| adc_data | input | 8 | Converter sample, valid on `smp_tick` |
| dig_in | input | 1 | Asynchronous digital read level |
| fifo_full | input | 1 | FIFO full flag; no write is made while it is high |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_din | output | 9 | FIFO word; bit 8 marks the header |

## Verification
The bench builds the block with its default parameters: 8-bit samples, eight samples per packet and a 4-bit sequence. With those values it can stream 34 packets in one run, which carries the sequence number twice across its wrap. Every word of every packet is predicted from an arithmetic function of the global sample index. The FIFO is run in three modes:
- always ready;
- full on one clock in three;
- held full across six packet periods, which forces a run of discards and a single flagged header.

Each tick the digital input is flipped one clock before the capture edge, so a synchroniser that is too short shows up as a wrong digital byte.

// File: rtl/spk_pkg.sv
package spk_pkg;
    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_HEAD = 2'd1,
        W_DATA = 2'd2,
        W_DIGI = 2'd3
    } wr_state_e;
endpackage

// File: rtl/spk_sync.sv
module spk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/spk_collect.sv
module spk_collect #(
    parameter int SAMPLE_W = 8,
    parameter int NSAMP    = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               tick,
    input  logic [SAMPLE_W-1:0]                adc,
    input  logic                               dig,
    output logic                               rdy,
    output logic [NSAMP-1:0][SAMPLE_W-1:0]     a_set,
    output logic [NSAMP-1:0]                   d_set
);
    localparam int            IW   = (NSAMP > 1) ? $clog2(NSAMP) : 1;
    localparam logic [IW-1:0] LAST = IW'(NSAMP - 1);

    logic [IW-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            rdy   <= 1'b0;
            a_set <= '0;
            d_set <= '0;
        end else begin
            rdy <= 1'b0;
            if (tick) begin
                a_set[idx] <= adc;
                d_set[idx] <= dig;
                if (idx == LAST) begin
                    idx <= '0;
                    rdy <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spk_writer.sv
module spk_writer
    import spk_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int NSAMP    = 8,
    parameter int SEQ_W    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rdy,
    input  logic [NSAMP-1:0][SAMPLE_W-1:0] a_in,
    input  logic [NSAMP-1:0]               d_in,
    input  logic                           fifo_full,
    output logic                           fifo_wr,
    output logic [SAMPLE_W:0]              fifo_din,
    output logic                           busy
);
    localparam int            IW   = (NSAMP > 1) ? $clog2(NSAMP) : 1;
    localparam logic [IW-1:0] LAST = IW'(NSAMP - 1);

    wr_state_e                     state, nstate;
    logic [NSAMP-1:0][SAMPLE_W-1:0] abuf;
    logic [NSAMP-1:0]               dbuf;
    logic [SAMPLE_W-1:0]            hdr_q, hdr_next, dig_word;
    logic [SEQ_W-1:0]               seq_q;
    logic                           ovf_q;
    logic [IW-1:0]                  idx;
    logic                           free, accept;

    // The writer can take a new packet when idle or while writing its last word.
    assign free   = (state == W_IDLE) || (state == W_DIGI && fifo_wr);
    assign accept = rdy && free;
    assign busy   = (state != W_IDLE);

    always_comb begin
        hdr_next              = '0;
        hdr_next[SEQ_W-1:0]   = seq_q;
        hdr_next[SEQ_W]       = ovf_q;
        dig_word              = '0;
        dig_word[NSAMP-1:0]   = dbuf;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            W_IDLE: if (rdy)     nstate = W_HEAD;
            W_HEAD: if (fifo_wr) nstate = W_DATA;
            W_DATA: if (fifo_wr && idx == LAST) nstate = W_DIGI;
            W_DIGI: if (fifo_wr) nstate = accept ? W_HEAD : W_IDLE;
            default: nstate = W_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= nstate;
    end

    // Packet buffer, sequence and overflow tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
            ovf_q <= 1'b0;
            abuf  <= '0;
            dbuf  <= '0;
            hdr_q <= '0;
            idx   <= '0;
        end else begin
            if (rdy) seq_q <= seq_q + 1'b1;
            if (accept) begin
                abuf  <= a_in;
                dbuf  <= d_in;
                hdr_q <= hdr_next;
                ovf_q <= 1'b0;
            end else if (rdy) begin
                ovf_q <= 1'b1;
            end
            if (fifo_wr) begin
                if (state == W_HEAD)      idx <= '0;
                else if (state == W_DATA) idx <= idx + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        fifo_wr  = (state != W_IDLE) && !fifo_full;
        fifo_din = '0;
        unique case (state)
            W_IDLE:  fifo_din = '0;
            W_HEAD:  fifo_din = {1'b1, hdr_q};
            W_DATA:  fifo_din = {1'b0, abuf[idx]};
            W_DIGI:  fifo_din = {1'b0, dig_word};
            default: fifo_din = '0;
        endcase
    end
endmodule

// File: rtl/sample_packetizer.sv
module sample_packetizer #(
    parameter int SAMPLE_W    = 8,
    parameter int PKT_SAMPLES = 8,
    parameter int SEQ_W       = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_tick,
    input  logic [SAMPLE_W-1:0] adc_data,
    input  logic                dig_in,
    input  logic                fifo_full,
    output logic                fifo_wr,
    output logic [SAMPLE_W:0]   fifo_din
);
    logic                              dig_s;
    logic                              pkt_rdy;
    logic [PKT_SAMPLES-1:0][SAMPLE_W-1:0] a_set;
    logic [PKT_SAMPLES-1:0]            d_set;
    logic                              wr_busy;

    spk_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dig_in),
        .q     (dig_s)
    );

    spk_collect #(.SAMPLE_W(SAMPLE_W), .NSAMP(PKT_SAMPLES)) u_coll (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (smp_tick),
        .adc   (adc_data),
        .dig   (dig_s),
        .rdy   (pkt_rdy),
        .a_set (a_set),
        .d_set (d_set)
    );

    spk_writer #(.SAMPLE_W(SAMPLE_W), .NSAMP(PKT_SAMPLES), .SEQ_W(SEQ_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdy       (pkt_rdy),
        .a_in      (a_set),
        .d_in      (d_set),
        .fifo_full (fifo_full),
        .fifo_wr   (fifo_wr),
        .fifo_din  (fifo_din),
        .busy      (wr_busy)
    );
endmodule

// File: rtl/spk_checker.sv
module spk_checker #(
    parameter int DW      = 9,
    parameter int PKT_LEN = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_full,
    input logic          fifo_wr,
    input logic [DW-1:0] fifo_din,
    input logic          busy
);
    localparam int CW = $clog2(PKT_LEN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (fifo_wr) cnt <= fifo_din[DW-1] ? CW'(1) : cnt + 1'b1;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !fifo_wr);

    a_r3_body_inside: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && !fifo_din[DW-1]) |-> (cnt != '0 && cnt < CW'(PKT_LEN)));

    a_r4_head_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && fifo_din[DW-1]) |-> (cnt == '0 || cnt == CW'(PKT_LEN)));

    a_r7_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_wr);

    a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fifo_full) |=> (busy && $stable(fifo_din)));
endmodule

bind sample_packetizer spk_checker #(.DW(SAMPLE_W + 1), .PKT_LEN(PKT_SAMPLES + 2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_full (fifo_full),
    .fifo_wr   (fifo_wr),
    .fifo_din  (fifo_din),
    .busy      (wr_busy)
);

// File: tb/sim_sample_packetizer.sv
`timescale 1ns/1ps
module sim_sample_packetizer;
    localparam int NPKT = 34;
    localparam int NSMP = NPKT * 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_tick = 1'b0;
    logic [7:0] adc_data = '0;
    logic       dig_in = 1'b0;
    logic       fifo_full = 1'b0;
    logic       fifo_wr;
    logic [8:0] fifo_din;

    int nchk = 0, nfail = 0;
    int phase = 0;
    int cyc = 0;
    int pos = 0, lastp = -1, curp = 0, ovf_hdrs = 0;

    always #10 clk = ~clk;

    sample_packetizer u0 (
        .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .adc_data(adc_data),
        .dig_in(dig_in), .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_din(fifo_din)
    );

    function automatic logic [7:0] adc_f(input int n);
        return 8'((n * 29 + 11) & 255);
    endfunction

    function automatic logic dig_f(input int n);
        return 1'((n ^ (n >> 3)) & 1);
    endfunction

    function automatic logic [7:0] digbyte_f(input int p);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[i] = dig_f(p * 8 + i);
        return b;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // FIFO full pattern per phase
    initial forever begin
        @(posedge clk); #1;
        cyc++;
        case (phase)
            1:       fifo_full = (cyc % 3 == 0);
            2:       fifo_full = 1'b1;
            default: fifo_full = 1'b0;
        endcase
    end

    // Output monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_full) chk(!fifo_wr, "R7 write while full", int'(fifo_wr), 0);
            if (fifo_wr) begin
                if (pos == 0) begin
                    int seq, ovf, e;
                    seq = int'(fifo_din[3:0]);
                    ovf = int'(fifo_din[4]);
                    chk(fifo_din[8] == 1'b1, "R4 header marker", int'(fifo_din[8]), 1);
                    chk(fifo_din[7:5] == 3'b0, "R5 header pad", int'(fifo_din[7:5]), 0);
                    e = lastp + 1;
                    while ((e % 16) != seq) e++;
                    if (lastp == -1) begin
                        chk(e == 0, "R1 first sequence", e, 0);
                        chk(ovf == 0, "R1 first overflow flag", ovf, 0);
                    end
                    chk(ovf == int'(e != lastp + 1), "R9 overflow flag", ovf, int'(e != lastp + 1));
                    if (e != lastp + 1)
                        chk(e >= 21 && e <= 26, "R8 unexpected gap", e, lastp + 1);
                    if (ovf == 1) ovf_hdrs++;
                    curp  = e;
                    lastp = e;
                end else if (pos <= 8) begin
                    chk(fifo_din[8] == 1'b0, "R4 body marker", int'(fifo_din[8]), 0);
                    chk(fifo_din[7:0] == adc_f(curp * 8 + pos - 1), "R3 analog byte",
                        int'(fifo_din[7:0]), int'(adc_f(curp * 8 + pos - 1)));
                end else begin
                    chk(fifo_din[8] == 1'b0, "R4 tail marker", int'(fifo_din[8]), 0);
                    chk(fifo_din[7:0] == digbyte_f(curp), "R2 R3 digital byte",
                        int'(fifo_din[7:0]), int'(digbyte_f(curp)));
                end
                pos = (pos == 9) ? 0 : pos + 1;
            end
        end
    end

    task automatic run_all();
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(!fifo_wr, "R1 idle after reset", int'(fifo_wr), 0);
        end
        @(posedge clk); #1;
        for (int n = 0; n < NSMP; n++) begin
            phase    = (n < 80) ? 0 : (n < 160) ? 1 : (n < 208) ? 2 : 3;
            adc_data = adc_f(n);
            dig_in   = dig_f(n);
            @(posedge clk); #1 dig_in = !dig_f(n);   // late change must be invisible (R2)
            @(posedge clk); #1 smp_tick = 1'b1;
            @(posedge clk); #1 smp_tick = 1'b0;
        end
        phase = 3;
        repeat (80) @(posedge clk);
        @(negedge clk);
        chk(pos == 0, "R3 packet boundary at end", pos, 0);
        chk(lastp == NPKT - 1, "R6 final packet number", lastp, NPKT - 1);
        chk(ovf_hdrs == 1, "R9 flagged header count", ovf_hdrs, 1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                nfail++;
                $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule